// File: doc/BRIEF.md
# Serial Video Deserializer and Framer

This block receives a recovered serial bit stream from a standard-definition serial digital video link, one bit per clock, and turns it into aligned 10-bit parallel words. First it removes the NRZI line coding. Then it descrambles with the self-synchronising polynomial x^9 + x^4 + 1. The recovered bits enter a 30-bit search window. In that window the block looks for the three-word timing reference preamble: one all-ones word followed by two all-zeros words.

The first preamble it finds sets the word boundary. From then on the block produces a parallel clock enable once every ten bit clocks, along with the newly completed word. It also produces a horizontal sync pulse on the word that ends each accepted preamble. A preamble can later appear at a different bit offset. In that case a realign-enable input decides whether the boundary moves to the new offset or stays where it is. The block flags the offset mismatch in either case.

In 8-bit mode, each word carries its payload in its upper eight bits. The two lowest bits of every output word are forced to zero, and they are ignored when the first preamble word is matched.

Top module: `svd_deserializer`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are cleared to zero on that edge. Reset is synchronous and active high.
- R2: Serial bits arrive LSB first. Before framing, each bit is NRZI-decoded (the decoded value is the XOR of the current and previous line bits) and then descrambled. The descrambled bit is the decoded value XORed with the decoded values 4 and 9 bits earlier. Every emitted word equals the 10 bits transmitted for that word.
- R3: Until the first preamble has been accepted, `pclk_en`, `hsync` and `sync_err` stay low.
- R4: A preamble is a 30-bit window holding 3FF hex followed by 000 and 000 hex, in order of arrival. It is accepted on the clock edge that takes in the last bit of the second 000 word. On that edge `hsync`, `pclk_en` and a `pdata` of 000 appear together, for one cycle.
- R5: Once locked, `pclk_en` is high for exactly one cycle in every ten. With each pulse, `pdata` shows the word whose last bit was taken in on that edge. Between pulses it is held.
- R6: When `word_8b` is high, bits 1:0 of `pdata` are zero. The first preamble word then matches whatever its two lowest bits are.
- R7: When locked, a preamble that ends away from the current boundary raises `sync_err` for one cycle on its final edge, whatever the value of `realign_en`.
- R8: With `realign_en` high, such a preamble moves the boundary. `hsync` and `pclk_en` are raised on its final edge, and `pclk_en` then repeats every ten cycles from there.
- R9: With `realign_en` low, such a preamble leaves the boundary unchanged and raises no `hsync`. `pclk_en` keeps its previous ten-cycle phase.
- R10: Reset also clears the lock. After reset, no `pclk_en` appears until a new preamble has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Recovered serial line bit, NRZI and scrambled |
| word_8b | input | 1 | 8-bit format: zero the two LSBs and ignore them in the preamble |
| realign_en | input | 1 | Allow a preamble at a new offset to move the word boundary |
| pdata | output | 10 | Aligned parallel word |
| pclk_en | output | 1 | One-in-ten parallel clock enable, marks a new word on `pdata` |
| hsync | output | 1 | One-cycle pulse on the last word of an accepted preamble |
| sync_err | output | 1 | One-cycle pulse when a preamble ends off the current boundary |

## Verification
The checker assumes that two preambles never end closer together than ten bits. This holds for any real stream, because each preamble contains twenty consecutive zero bits. The checker also assumes that `realign_en` and `word_8b` are steady across the edge whose effect it examines. The stimulus changes those two controls only between whole words. Its filler words have a one in bits 0 and 5, so no zero run reaches twenty bits and no preamble can form except where the bench places one. After a reset the stream runs thirty filler words before the next preamble, which gives the descrambler time to resynchronise first.

// File: rtl/svd_pkg.sv
package svd_pkg;

    localparam int WORD_W   = 10;
    localparam int NWORDS   = 3;
    localparam int WIN_W    = WORD_W * NWORDS;
    localparam int POLY_LEN = 9;
    localparam int POLY_TAP = 4;
    localparam int PAD_8B   = 2;
    localparam int PH_W     = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WIN_W-1:0]  win_t;

    typedef struct packed {
        logic  pclk_en;
        logic  hsync;
        logic  sync_err;
        word_t data;
    } frm_out_t;

    // preamble: oldest word all ones (low bits), then zeros
    function automatic win_t pre_pattern();
        return {{(WIN_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
    endfunction

    function automatic logic pre_match(input win_t w, input logic f8);
        win_t care;
        care = f8 ? ~win_t'((1 << PAD_8B) - 1) : '1;
        return ((w ^ pre_pattern()) & care) == '0;
    endfunction

    function automatic word_t fmt_mask(input word_t w, input logic f8);
        return f8 ? {w[WORD_W-1:PAD_8B], {PAD_8B{1'b0}}} : w;
    endfunction

endpackage

// File: rtl/svd_descrambler.sv
module svd_descrambler
    import svd_pkg::*;
#(
    parameter int LEN = POLY_LEN,
    parameter int TAP = POLY_TAP
) (
    input  logic clk,
    input  logic rst,
    input  logic line_bit,
    output logic data_bit
);

    logic           prev_q;
    logic [LEN-1:0] hist_q;
    logic           nrz;

    always_comb begin
        nrz      = line_bit ^ prev_q;
        data_bit = nrz ^ hist_q[TAP-1] ^ hist_q[LEN-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            hist_q <= '0;
        end else begin
            prev_q <= line_bit;
            hist_q <= {hist_q[LEN-2:0], nrz};
        end
    end

endmodule

// File: rtl/svd_window.sv
module svd_window
    import svd_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int NW = NWORDS,
    localparam int SW = WW * NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_bit,
    input  logic          word_8b,
    output logic [WW-1:0] newest,
    output logic          hit
);

    logic [SW-1:0] sr_q;
    logic [SW-1:0] sr_nxt;

    // LSB first: new bit enters at the top, oldest leaves at bit 0
    always_comb begin
        sr_nxt = {data_bit, sr_q[SW-1:1]};
        newest = sr_nxt[SW-1 -: WW];
        hit    = pre_match(sr_nxt, word_8b);
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_nxt;
    end

endmodule

// File: rtl/svd_timing.sv
module svd_timing
    import svd_pkg::*;
#(
    parameter int WW = WORD_W,
    localparam int PW = $clog2(WW)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  logic     realign_en,
    input  logic     word_8b,
    input  word_t    newest,
    output frm_out_t fo
);

    logic [PW-1:0] phase_q;
    logic          locked_q;
    logic          aligned;
    logic          accept;
    logic          emit;
    frm_out_t      fo_q;

    always_comb begin
        aligned = phase_q == PW'(WW - 1);
        accept  = hit && (!locked_q || realign_en || aligned);
        emit    = accept || (locked_q && aligned);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            locked_q <= 1'b0;
            fo_q     <= '0;
        end else begin
            phase_q       <= (accept || aligned) ? '0 : phase_q + 1'b1;
            locked_q      <= locked_q | accept;
            fo_q.pclk_en  <= emit;
            fo_q.hsync    <= accept;
            fo_q.sync_err <= hit && locked_q && !aligned;
            if (emit) fo_q.data <= fmt_mask(newest, word_8b);
        end
    end

    assign fo = fo_q;

endmodule

// File: rtl/svd_deserializer.sv
module svd_deserializer
    import svd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              word_8b,
    input  logic              realign_en,
    output logic [WORD_W-1:0] pdata,
    output logic              pclk_en,
    output logic              hsync,
    output logic              sync_err
);

    logic     dbit;
    logic     hit;
    word_t    newest;
    frm_out_t fo;

    svd_descrambler #(.LEN(POLY_LEN), .TAP(POLY_TAP)) u_dsc (
        .clk      (clk),
        .rst      (rst),
        .line_bit (sdi),
        .data_bit (dbit)
    );

    svd_window #(.WW(WORD_W), .NW(NWORDS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .data_bit (dbit),
        .word_8b  (word_8b),
        .newest   (newest),
        .hit      (hit)
    );

    svd_timing #(.WW(WORD_W)) u_tim (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .realign_en (realign_en),
        .word_8b    (word_8b),
        .newest     (newest),
        .fo         (fo)
    );

    assign pdata    = fo.data;
    assign pclk_en  = fo.pclk_en;
    assign hsync    = fo.hsync;
    assign sync_err = fo.sync_err;

endmodule

// File: rtl/svd_chk.sv
module svd_chk
    import svd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              word_8b,
    input logic              realign_en,
    input logic [WORD_W-1:0] pdata,
    input logic              pclk_en,
    input logic              hsync,
    input logic              sync_err
);

    logic          seen_q;
    logic [PH_W:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            seen_q <= seen_q | hsync;
            if (pclk_en)                gap_q <= '0;
            else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!pclk_en && !hsync && !sync_err && pdata == '0));

    // R4
    hs_word_chk: assert property (@(posedge clk) disable iff (rst)
        hsync |-> (pclk_en && pdata == '0));

    // R3
    lock_first_chk: assert property (@(posedge clk) disable iff (rst)
        (pclk_en || sync_err) |-> (hsync || seen_q));

    // R5
    period_chk: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && seen_q && gap_q != (PH_W+1)'(WORD_W - 1)) |-> (sync_err && $past(realign_en)));

    // R6
    lsb8_chk: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && $past(word_8b)) |-> (pdata[PAD_8B-1:0] == '0));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    // R8
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_err && $past(realign_en)) |-> (hsync && pclk_en));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_err && !$past(realign_en)) |-> !hsync);

endmodule

bind svd_deserializer svd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_8b    (word_8b),
    .realign_en (realign_en),
    .pdata      (pdata),
    .pclk_en    (pclk_en),
    .hsync      (hsync),
    .sync_err   (sync_err)
);

// File: tb/sim_svd_deserializer.sv
module sim_svd_deserializer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdi = 1'b0;
    logic       word_8b = 1'b0;
    logic       realign_en = 1'b1;
    logic [9:0] pdata;
    logic       pclk_en;
    logic       hsync;
    logic       sync_err;

    int n_chk = 0;
    int n_bad = 0;

    // transmit-side model state
    logic [8:0] eh = '0;
    logic       er = 1'b0;
    // expected framing state
    int  ph = 0;
    bit  lk = 1'b0;
    bit  last_emit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svd_deserializer u0 (
        .clk(clk), .rst(rst), .sdi(sdi), .word_8b(word_8b),
        .realign_en(realign_en), .pdata(pdata), .pclk_en(pclk_en),
        .hsync(hsync), .sync_err(sync_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // scramble, NRZI-encode, drive one bit; check outputs after its edge
    task automatic send_bit(input logic b, input bit pre_end);
        logic s;
        bit aligned, accept, err, emit;
        s  = b ^ eh[3] ^ eh[8];
        eh = {eh[7:0], s};
        er = er ^ s;
        sdi = er;
        @(negedge clk);
        aligned = (ph == 9);
        accept  = pre_end && (!lk || realign_en || aligned);
        err     = pre_end && lk && !aligned;
        emit    = accept || (lk && aligned);
        check(pclk_en == emit, !lk ? "R3" : (err && realign_en) ? "R8" : (err ? "R9" : "R5"),
              "pclk_en", pclk_en, emit);
        check(hsync == accept, (pre_end && !realign_en) ? "R9" : "R4", "hsync", hsync, accept);
        check(sync_err == err, "R7", "sync_err", sync_err, err);
        last_emit = emit;
        ph = (accept || ph == 9) ? 0 : ph + 1;
        if (accept) lk = 1'b1;
    endtask

    task automatic send_word(input logic [9:0] w, input bit pre_end);
        logic [9:0] exp;
        for (int i = 0; i < 10; i++) send_bit(w[i], pre_end && i == 9);
        exp = word_8b ? {w[9:2], 2'b00} : w;
        if (last_emit)
            check(pdata == exp, word_8b ? "R6" : "R2", "pdata", pdata, exp);
    endtask

    task automatic send_pre(input logic [9:0] first);
        send_word(first, 1'b0);
        send_word(10'h000, 1'b0);
        send_word(10'h000, 1'b1);
    endtask

    function automatic logic [9:0] fill(input int i, input int seed);
        return 10'((i * 97 + seed) & 10'h3FF) | 10'h021;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(pdata == 10'h0 && !pclk_en && !hsync && !sync_err, "R1", "reset outputs",
              {pdata, pclk_en, hsync, sync_err}, 0);

        // R3: filler only, no lock
        for (int i = 0; i < 20; i++) send_word(fill(i, 13), 1'b0);

        // R4, R2, R5: first preamble, then data words
        send_pre(10'h3FF);
        check(pdata == 10'h000, "R4", "preamble end word", pdata, 0);
        for (int i = 0; i < 20; i++) send_word(fill(i, 301), 1'b0);

        // R9, R7: misaligned preamble with realign disabled
        realign_en = 1'b0;
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
        send_pre(10'h3FF);
        for (int i = 0; i < 10; i++) send_word(fill(i, 77), 1'b0);

        // R8, R7: misaligned preamble with realign enabled
        realign_en = 1'b1;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        send_pre(10'h3FF);
        for (int i = 0; i < 12; i++) send_word(fill(i, 555), 1'b0);

        // R6: 8-bit format, first preamble word with nonzero LSBs
        word_8b = 1'b1;
        send_pre(10'h3FD);
        for (int i = 0; i < 12; i++) send_word(fill(i, 902) | 10'h003, 1'b0);
        // R6 + R8: realign in 8-bit mode
        for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
        send_pre(10'h3FE);
        for (int i = 0; i < 6; i++) send_word(fill(i, 41), 1'b0);
        word_8b = 1'b0;

        // R10: mid-stream reset clears lock
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lk = 1'b0;
        ph = 0;
        check(pdata == 10'h0 && !pclk_en && !hsync, "R10", "outputs after reset",
              {pdata, pclk_en, hsync}, 0);
        for (int i = 0; i < 30; i++) send_word(fill(i, 219), 1'b0);
        send_pre(10'h3FF);
        for (int i = 0; i < 10; i++) send_word(fill(i, 640), 1'b0);

        summary();
    end

endmodule